// File: doc/BRIEF.md
# Dual-Read Register Bank with Same-Cycle Write Forwarding

This block is the working register bank of a small 8-bit pipelined processor core. It holds sixteen 8-bit registers. Two read ports return register contents combinationally and can be used together. One write port updates a register on the rising clock edge.

When a read port selects the register that is being written in the same cycle, that port returns the incoming write data instead of the old stored value. The ports make this comparison independently of each other. Because of this forwarding, the hazard logic of the pipeline does not have to treat an instruction in its last stage as a conflict.

All pins are plain control and data wires. There is no stream handshake, because every read completes in the cycle it is asked for and every write is accepted in the cycle it is presented, so there is nothing to stall.

Top module: `regfile_bypass`

## Requirements
- R1: The bank holds 16 registers of 8 bits each. Register n is selected by the 4-bit binary value n on any address input.
- R2: With `wr_en` high and `rst` low, `wr_data` is stored into register `wr_addr` at the rising clock edge. From the next cycle on it is returned by any read port that selects that register.
- R3: With `wr_en` low, no register changes at the clock edge.
- R4: A synchronous active-high `rst` clears every register to zero at the clock edge. A write requested in the same cycle is ignored. While `rst` is high, the read ports return the stored contents without forwarding.
- R5: Port A forwards when `wr_en` is high, `rst` is low and `rd_addr_a` equals `wr_addr`. In that case `rd_data_a` equals `wr_data` in the same cycle, with no clock edge needed.
- R6: Port B forwards under the same conditions using `rd_addr_b`. Its decision does not depend on port A's address.
- R7: With `wr_en` low, both read ports return the stored contents combinationally, even when a read address equals `wr_addr`.
- R8: The two read ports can select different registers in the same cycle, and each returns its own register's contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; storage updates on the rising edge |
| rst | input | 1 | Synchronous active-high clear of all registers |
| rd_addr_a | input | 4 | Register selected by read port A |
| rd_data_a | output | 8 | Data for read port A (forwarded or stored) |
| rd_addr_b | input | 4 | Register selected by read port B |
| rd_data_b | output | 8 | Data for read port B (forwarded or stored) |
| wr_en | input | 1 | Write request for this cycle |
| wr_addr | input | 4 | Register to be written |
| wr_data | input | 8 | Value to be written |

## Verification
The bench samples each read port before the clock edge while a write to the same register is pending. A bank without forwarding would show the old value there, and a bank that forwards on both ports from one comparison would corrupt the port that selects a different register. It also presents a matching address with `wr_en` low, where a bank that forwards without checking the enable would leak `wr_data` onto the port. Finally, it requests a write during reset, where a bank that lets the write win over the clear would leave a nonzero register afterwards.

// File: rtl/rf_pkg.sv
package rf_pkg;
  localparam int RF_DEF_DATA_W = 8;
  localparam int RF_DEF_DEPTH  = 16;

  // Where a read port takes its value from in the current cycle
  typedef enum logic {
    SRC_STORE  = 1'b0,
    SRC_BYPASS = 1'b1
  } rd_src_e;
endpackage

// File: rtl/rf_storage.sv
module rf_storage #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_fire,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] regs_q [DEPTH]
);
  for (genvar g = 0; g < DEPTH; g++) begin : g_reg
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(g);
    always_ff @(posedge clk) begin
      if (rst)
        regs_q[g] <= '0;
      else if (wr_fire && (wr_addr == MY_ADDR))
        regs_q[g] <= wr_data;
    end
  end
endmodule

// File: rtl/rf_read_port.sv
module rf_read_port
  import rf_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic [DATA_W-1:0] regs_q [DEPTH],
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              wr_fire,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data
);
  rd_src_e           src;
  logic [DATA_W-1:0] stored;

  always_comb begin
    stored = '0;
    for (int i = 0; i < DEPTH; i++)
      if (rd_addr == ADDR_W'(i)) stored = regs_q[i];
  end

  assign src = (wr_fire && (wr_addr == rd_addr)) ? SRC_BYPASS : SRC_STORE;

  always_comb begin
    unique case (src)
      SRC_BYPASS: rd_data = wr_data;
      default:    rd_data = stored;
    endcase
  end
endmodule

// File: rtl/regfile_bypass.sv
module regfile_bypass #(
  parameter int DATA_W = rf_pkg::RF_DEF_DATA_W,
  parameter int DEPTH  = rf_pkg::RF_DEF_DEPTH,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] rd_addr_a,
  output logic [DATA_W-1:0] rd_data_a,
  input  logic [ADDR_W-1:0] rd_addr_b,
  output logic [DATA_W-1:0] rd_data_b,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data
);
  localparam int NPORTS = 2;

  logic              wr_fire;
  logic [DATA_W-1:0] regs_q [DEPTH];
  logic [ADDR_W-1:0] rd_addr [NPORTS];
  logic [DATA_W-1:0] rd_data [NPORTS];

  assign wr_fire    = wr_en && !rst;
  assign rd_addr[0] = rd_addr_a;
  assign rd_addr[1] = rd_addr_b;
  assign rd_data_a  = rd_data[0];
  assign rd_data_b  = rd_data[1];

  rf_storage #(.DATA_W(DATA_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_store (
    .clk     (clk),
    .rst     (rst),
    .wr_fire (wr_fire),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .regs_q  (regs_q)
  );

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    rf_read_port #(.DATA_W(DATA_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_rd (
      .regs_q  (regs_q),
      .rd_addr (rd_addr[p]),
      .wr_fire (wr_fire),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .rd_data (rd_data[p])
    );
  end
endmodule

// File: rtl/rf_checker.sv
module rf_checker #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] rd_addr_a,
  input logic [DATA_W-1:0] rd_data_a,
  input logic [ADDR_W-1:0] rd_addr_b,
  input logic [DATA_W-1:0] rd_data_b,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data
);
  AST_FWD_PORT_A: assert property (@(posedge clk) disable iff (rst)
    (wr_en && rd_addr_a == wr_addr) |-> rd_data_a == wr_data); // R5

  AST_FWD_PORT_B: assert property (@(posedge clk) disable iff (rst)
    (wr_en && rd_addr_b == wr_addr) |-> rd_data_b == wr_data); // R6

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
    (wr_en && rd_addr_a == wr_addr) |=>
      (rd_addr_a != $past(rd_addr_a) || (wr_en && wr_addr == rd_addr_a)
       || rd_data_a == $past(wr_data))); // R2

  AST_NO_WE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> (rd_addr_b != $past(rd_addr_b) || (wr_en && wr_addr == rd_addr_b)
                || $stable(rd_data_b))); // R3

  AST_RESET_ZERO: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) && !(wr_en && wr_addr == rd_addr_a)) |-> rd_data_a == '0); // R4
endmodule

bind regfile_bypass rf_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .rd_addr_a (rd_addr_a),
  .rd_data_a (rd_data_a),
  .rd_addr_b (rd_addr_b),
  .rd_data_b (rd_data_b),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .wr_data   (wr_data)
);

// File: tb/tb_regfile_bypass.sv
module tb_regfile_bypass;
  logic       clk = 1'b0;
  logic       rst;
  logic [3:0] rd_addr_a, rd_addr_b, wr_addr;
  logic [7:0] rd_data_a, rd_data_b, wr_data;
  logic       wr_en;
  int         n_chk = 0;
  int         n_fail = 0;

  always #2 clk = ~clk;

  regfile_bypass dut (
    .clk(clk), .rst(rst),
    .rd_addr_a(rd_addr_a), .rd_data_a(rd_data_a),
    .rd_addr_b(rd_addr_b), .rd_data_b(rd_data_b),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  function automatic logic [7:0] pat(input int i);
    return 8'(8'h11 * i + 8'h07);
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic write_reg(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic t_reset_clear();
    @(negedge clk);
    rst = 1'b1; wr_en = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 16; i++) begin
      rd_addr_a = 4'(i); rd_addr_b = 4'(15 - i);
      #1;
      check("R4 reset port A", rd_data_a, 8'h00);
      check("R4 reset port B", rd_data_b, 8'h00);
    end
  endtask

  task automatic t_fill_and_read();
    for (int i = 0; i < 16; i++) write_reg(4'(i), pat(i));
    @(negedge clk);
    for (int i = 0; i < 16; i++) begin
      rd_addr_a = 4'(i); rd_addr_b = 4'(15 - i);
      #1;
      check("R1 R2 stored value port A", rd_data_a, pat(i));
      check("R8 independent port B", rd_data_b, pat(15 - i));
    end
  endtask

  task automatic t_bypass_a();
    @(negedge clk);
    rd_addr_a = 4'd5; rd_addr_b = 4'd6;
    wr_en = 1'b1; wr_addr = 4'd5; wr_data = 8'hA5;
    #1;
    check("R5 port A forwards", rd_data_a, 8'hA5);
    check("R6 port B not forwarded", rd_data_b, pat(6));
    @(negedge clk);
    wr_en = 1'b0;
    #1;
    check("R2 port A after edge", rd_data_a, 8'hA5);
  endtask

  task automatic t_bypass_b();
    @(negedge clk);
    rd_addr_a = 4'd9; rd_addr_b = 4'd12;
    wr_en = 1'b1; wr_addr = 4'd12; wr_data = 8'h3C;
    #1;
    check("R6 port B forwards", rd_data_b, 8'h3C);
    check("R5 port A not forwarded", rd_data_a, pat(9));
    @(negedge clk);
    wr_en = 1'b0;
    #1;
    check("R2 port B after edge", rd_data_b, 8'h3C);
  endtask

  task automatic t_bypass_both();
    @(negedge clk);
    rd_addr_a = 4'd0; rd_addr_b = 4'd0;
    wr_en = 1'b1; wr_addr = 4'd0; wr_data = 8'hE1;
    #1;
    check("R5 both ports same reg A", rd_data_a, 8'hE1);
    check("R6 both ports same reg B", rd_data_b, 8'hE1);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic t_no_enable();
    @(negedge clk);
    rd_addr_a = 4'd3; rd_addr_b = 4'd3;
    wr_en = 1'b0; wr_addr = 4'd3; wr_data = 8'hFF;
    #1;
    check("R7 no forward port A", rd_data_a, pat(3));
    check("R7 no forward port B", rd_data_b, pat(3));
    @(negedge clk);
    #1;
    check("R3 register unchanged", rd_data_a, pat(3));
  endtask

  task automatic t_reset_beats_write();
    @(negedge clk);
    rst = 1'b1; wr_en = 1'b1; wr_addr = 4'd7; wr_data = 8'h5A;
    rd_addr_a = 4'd7; rd_addr_b = 4'd1;
    #1;
    check("R4 no forward in reset", rd_data_a, pat(7));
    @(negedge clk);
    rst = 1'b0; wr_en = 1'b0;
    #1;
    check("R4 write ignored in reset", rd_data_a, 8'h00);
    check("R4 other reg cleared", rd_data_b, 8'h00);
  endtask

  initial begin
    #(4 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    rd_addr_a = '0; rd_addr_b = '0;
    t_reset_clear();
    t_fill_and_read();
    t_bypass_a();
    t_bypass_b();
    t_bypass_both();
    t_no_enable();
    t_reset_beats_write();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule